// File: doc/BRIEF.md
# Periodic and One-Shot Comparator Timer

The block holds a 32-bit main counter and a parameterised set of comparator channels. The counter counts up by one each clock while a global run bit is set. Each channel compares its compare value against the counter and raises a fire pulse for one cycle on a match. A channel works in one of two modes. In one-shot mode the compare value stays where software left it. In periodic mode the channel reloads itself by adding its period after every match.

Software uses a single write port with byte-lane enables to program the run bit, the counter and each channel's configuration, compare value and period. A combinational read port returns any of these registers. In periodic mode the compare register address writes the period. The same write also loads the compare value when the channel's value-set bit is armed, and that bit clears itself.

A periodic channel can find the counter already beyond its compare value. This happens after the counter is rewritten, after the run bit turns on, or after a compare write. The channel then moves its compare value forward by whole periods until it is ahead of the counter. This is done by repeated addition, one period per cycle, and the fire output is held off while it runs. The fire pulses are raw events. Interrupt status, routing and delivery are the job of a separate block.

Top module: `tmr_comparator_timer`

## Requirements
- R1: After reset the counter reads 0, the run bit reads 0, every channel's compare value reads 0xFFFFFFFF, every period reads 0, every configuration reads 0 and no fire output is high.
- R2: While the run bit (control register at address 0, bit 0) is 1 the counter rises by one each clock. While it is 0 the counter holds its value.
- R3: A write to the counter (address 1) replaces only the byte lanes whose enable bit is set and takes precedence over counting. A lane-masked write keeps the other bytes of the old value.
- R4: A channel's fire output is high for a cycle exactly when the run bit is 1, the counter equals that channel's compare value and the channel is not catching up.
- R5: In one-shot mode (configuration bit 0 = 0) a compare write changes only the enabled byte lanes of the compare value, and the period stays 0. A match leaves the compare value unchanged. A compare value the counter has already passed fires only after the counter wraps through zero.
- R6: In periodic mode (configuration bit 0 = 1) a compare write loads the period. If the value-set bit (configuration bit 1) is 1, the same write also loads the compare value. Any compare write clears the value-set bit.
- R7: In periodic mode, on the clock edge that ends a fire pulse, the compare value becomes compare value plus period (modulo 2^32).
- R8: Writing a configuration with bit 0 = 0 forces the channel's period to 0.
- R9: After a counter write, a rising run bit or any write to a periodic channel, a periodic channel with non-zero period checks the counter in the next cycle. If the counter is greater than the compare value (unsigned), the compare value becomes cmp + ((cnt - cmp)/period + 1) * period in 32-bit wrapping arithmetic, where cnt is the counter in that check cycle. This is reached by one period addition per cycle, and fire is held low during those cycles.
- R10: Reads return the control register at address 0, the counter at 1, and for channel i at base 4 + 4*i the configuration (offset 0), compare value (offset 1) and period (offset 2). Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| wr_be | input | 4 | Byte-lane enables for the write |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Combinational read data |
| fire | output | NUM_CH | One-cycle match pulse per channel |

## Verification
The assertions that relate a compare value to its previous value assume that no write or rearm event lands on the channel in that cycle. They are therefore conditioned on the channel's own event signal, and any write is allowed at any time. The catch-up assertions take as given that the period register holds its value while stepping. This is true because only a write, which restarts the check, can change it. The stimulus picks periods and distances that keep each catch-up within a few dozen cycles. One case is built on purpose so that a running counter passes the target during catch-up, and the fire pulse is then expected to be missed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int unsigned TW = 32;
  localparam int unsigned BW = TW / 8;

  typedef logic [TW-1:0] tword_t;
  typedef logic [BW-1:0] tbe_t;

  localparam int unsigned OFS_CFG = 0;
  localparam int unsigned OFS_CMP = 1;
  localparam int unsigned OFS_PER = 2;

  localparam int unsigned CFG_PERIODIC = 0;
  localparam int unsigned CFG_VSET     = 1;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_CHECK = 2'd1,
    CH_CATCH = 2'd2
  } ch_state_e;

  function automatic tword_t lane_merge(tword_t old_v, tword_t new_v, tbe_t be);
    tword_t r;
    for (int b = 0; b < int'(BW); b++) begin
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    end
    return r;
  endfunction

  function automatic logic is_behind(tword_t cnt, tword_t cmp);
    return cnt > cmp;
  endfunction

  function automatic tword_t step_cmp(tword_t cmp, tword_t per);
    return cmp + per;
  endfunction
endpackage

// File: rtl/tmr_main_counter.sv
module tmr_main_counter
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_ctl,
  input  logic   wr_cnt,
  input  tword_t wr_data,
  input  tbe_t   wr_be,
  output tword_t cnt,
  output logic   run,
  output logic   rearm
);
  tword_t cnt_q;
  logic   run_q;
  logic   run_rise;

  assign run_rise = wr_ctl && wr_be[0] && wr_data[0] && !run_q;
  assign rearm    = run_rise || wr_cnt;
  assign cnt      = cnt_q;
  assign run      = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (wr_ctl && wr_be[0]) run_q <= wr_data[0];
      if (wr_cnt)     cnt_q <= lane_merge(cnt_q, wr_data, wr_be);
      else if (run_q) cnt_q <= cnt_q + TW'(1);
    end
  end

  // R2: counter holds while stopped
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_cnt) |=> $stable(cnt_q));
  // R2: counter steps by one while running
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wr_cnt) |=> (cnt_q == $past(cnt_q) + TW'(1)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  tword_t cnt,
  input  logic   rearm,
  input  logic   wr_cfg,
  input  logic   wr_cmp,
  input  tword_t wr_data,
  input  tbe_t   wr_be,
  output logic   fire,
  output tword_t cmp,
  output tword_t period,
  output logic   periodic,
  output logic   vset
);
  tword_t    cmp_q, per_q, dist_q;
  logic      periodic_q, vset_q;
  ch_state_e state_q;

  logic ch_event;
  logic catching;
  logic start_catch;
  logic last_step;
  logic advance;
  logic match;

  assign ch_event    = rearm || wr_cfg || wr_cmp;
  assign catching    = (state_q == CH_CATCH);
  assign match       = run && (cnt == cmp_q);
  assign fire        = match && !catching;
  assign start_catch = (state_q == CH_CHECK) && periodic_q && (per_q != '0)
                       && is_behind(cnt, cmp_q);
  assign last_step   = catching && (dist_q < per_q);
  assign advance     = !ch_event && (catching || (fire && periodic_q));

  assign cmp      = cmp_q;
  assign period   = per_q;
  assign periodic = periodic_q;
  assign vset     = vset_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q      <= '1;
      per_q      <= '0;
      dist_q     <= '0;
      periodic_q <= 1'b0;
      vset_q     <= 1'b0;
      state_q    <= CH_IDLE;
    end else begin
      if (wr_cfg && wr_be[0]) begin
        periodic_q <= wr_data[CFG_PERIODIC];
        vset_q     <= wr_data[CFG_VSET];
        if (!wr_data[CFG_PERIODIC]) per_q <= '0;
      end
      if (wr_cmp) begin
        if (periodic_q) begin
          per_q <= lane_merge(per_q, wr_data, wr_be);
          if (vset_q) cmp_q <= lane_merge(cmp_q, wr_data, wr_be);
        end else begin
          cmp_q <= lane_merge(cmp_q, wr_data, wr_be);
        end
        vset_q <= 1'b0;
      end
      if (advance) cmp_q <= step_cmp(cmp_q, per_q);

      if (ch_event) begin
        state_q <= CH_CHECK;
      end else begin
        unique case (state_q)
          CH_CHECK: begin
            state_q <= start_catch ? CH_CATCH : CH_IDLE;
            dist_q  <= cnt - cmp_q;
          end
          CH_CATCH: begin
            if (last_step) state_q <= CH_IDLE;
            else           dist_q  <= dist_q - per_q;
          end
          default: state_q <= CH_IDLE;
        endcase
      end
    end
  end

  // R7: a periodic match moves the compare value on by one period
  a_r7_periodic_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && periodic_q && !ch_event) |=> (cmp_q == $past(cmp_q + per_q)));
  // R9: each catch-up cycle adds exactly one period
  a_r9_catch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (catching && !ch_event) |=> (cmp_q == $past(cmp_q + per_q)));
  // R8: a one-shot channel never holds a period
  a_r8_oneshot_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic_q |-> (per_q == '0));
  // R6: value-set is gone after any compare write
  a_r6_vset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmp |=> !vset_q);
  // R5: without writes a one-shot compare value never moves
  a_r5_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic_q && !ch_event) |=> $stable(cmp_q));
endmodule

// File: rtl/tmr_comparator_timer.sv
module tmr_comparator_timer
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CH_BASE   = 4,
  parameter int unsigned CH_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TW-1:0]     wr_data,
  input  logic [BW-1:0]     wr_be,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TW-1:0]     rd_data,
  output logic [NUM_CH-1:0] fire
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);

  tword_t cnt;
  logic   run;
  logic   rearm;
  logic   wr_ctl, wr_cnt;

  tword_t cmp_a    [NUM_CH];
  tword_t per_a    [NUM_CH];
  logic   pmode_a  [NUM_CH];
  logic   vset_a   [NUM_CH];

  assign wr_ctl = wr_en && (wr_addr == A_CTRL);
  assign wr_cnt = wr_en && (wr_addr == A_CNT);

  tmr_main_counter u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctl  (wr_ctl),
    .wr_cnt  (wr_cnt),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .cnt     (cnt),
    .run     (run),
    .rearm   (rearm)
  );

  for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(CH_BASE + i * CH_STRIDE);
    logic wr_cfg_i, wr_cmp_i;
    assign wr_cfg_i = wr_en && (wr_addr == A_BASE + ADDR_W'(OFS_CFG));
    assign wr_cmp_i = wr_en && (wr_addr == A_BASE + ADDR_W'(OFS_CMP));

    tmr_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .cnt      (cnt),
      .rearm    (rearm),
      .wr_cfg   (wr_cfg_i),
      .wr_cmp   (wr_cmp_i),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .fire     (fire[i]),
      .cmp      (cmp_a[i]),
      .period   (per_a[i]),
      .periodic (pmode_a[i]),
      .vset     (vset_a[i])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) rd_data = {{(TW-1){1'b0}}, run};
    if (rd_addr == A_CNT)  rd_data = cnt;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (rd_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFS_CFG))
        rd_data = {{(TW-2){1'b0}}, vset_a[i], pmode_a[i]};
      if (rd_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFS_CMP))
        rd_data = cmp_a[i];
      if (rd_addr == ADDR_W'(CH_BASE + i * CH_STRIDE + OFS_PER))
        rd_data = per_a[i];
    end
  end

  // R4: no fire pulse while the counter is stopped
  a_r4_fire_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |-> (rd_addr == rd_addr) && run);
endmodule

// File: tb/tmr_comparator_timer_bench.sv
module tmr_comparator_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_be = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NCH-1:0] fire;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_comparator_timer #(.NUM_CH(NCH), .ADDR_W(AW), .CH_BASE(4), .CH_STRIDE(4))
    u_tmr_comparator_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr),
      .rd_data(rd_data), .fire(fire));

  // behavioural reference state
  bit          m_run;
  int unsigned m_cnt;
  int unsigned m_cmp [NCH];
  int unsigned m_per [NCH];
  bit          m_pm  [NCH];
  bit          m_vs  [NCH];
  bit          m_pend[NCH];
  int unsigned m_left[NCH];

  function automatic int unsigned mrg(int unsigned o, int unsigned n, bit [3:0] be);
    int unsigned r = o;
    for (int b = 0; b < 4; b++) if (be[b]) begin
      r = r & ~(32'hFF << (8*b));
      r = r | (n & (32'hFF << (8*b)));
    end
    return r;
  endfunction

  function automatic bit m_fire(int i);
    return m_run && (m_cnt == m_cmp[i]) && (m_left[i] == 0);
  endfunction

  function automatic int unsigned m_read(int a);
    if (a == 0) return {31'd0, m_run};
    if (a == 1) return m_cnt;
    for (int i = 0; i < NCH; i++) begin
      if (a == 4 + 4*i) return {30'd0, m_vs[i], m_pm[i]};
      if (a == 5 + 4*i) return m_cmp[i];
      if (a == 6 + 4*i) return m_per[i];
    end
    return 0;
  endfunction

  task automatic model_reset();
    m_run = 0; m_cnt = 0;
    for (int i = 0; i < NCH; i++) begin
      m_cmp[i] = 32'hFFFF_FFFF; m_per[i] = 0; m_pm[i] = 0; m_vs[i] = 0;
      m_pend[i] = 0; m_left[i] = 0;
    end
  endtask

  task automatic model_step();
    bit f [NCH];
    bit wc = wr_en && wr_addr == 0;
    bit wn = wr_en && wr_addr == 1;
    bit restart = (wc && wr_be[0] && wr_data[0] && !m_run) || wn;
    int unsigned cnt_now = m_cnt;
    for (int i = 0; i < NCH; i++) f[i] = m_fire(i);
    if (wn) m_cnt = mrg(m_cnt, wr_data, wr_be);
    else if (m_run) m_cnt = m_cnt + 1;
    if (wc && wr_be[0]) m_run = wr_data[0];
    for (int i = 0; i < NCH; i++) begin
      bit wg = wr_en && wr_addr == AW'(4 + 4*i);
      bit wp = wr_en && wr_addr == AW'(5 + 4*i);
      if (wg && wr_be[0]) begin
        m_pm[i] = wr_data[0]; m_vs[i] = wr_data[1];
        if (!wr_data[0]) m_per[i] = 0;
      end
      if (wp) begin
        if (m_pm[i]) begin
          if (m_vs[i]) m_cmp[i] = mrg(m_cmp[i], wr_data, wr_be);
          m_per[i] = mrg(m_per[i], wr_data, wr_be);
        end else m_cmp[i] = mrg(m_cmp[i], wr_data, wr_be);
        m_vs[i] = 0;
      end
      if (restart || wg || wp) begin
        m_pend[i] = 1; m_left[i] = 0;
      end else if (m_left[i] != 0) begin
        m_cmp[i] = m_cmp[i] + m_per[i];
        m_left[i] = m_left[i] - 1;
      end else begin
        if (m_pend[i] && m_pm[i] && m_per[i] != 0 && cnt_now > m_cmp[i])
          m_left[i] = (cnt_now - m_cmp[i]) / m_per[i] + 1;
        else if (f[i] && m_pm[i]) m_cmp[i] = m_cmp[i] + m_per[i];
        m_pend[i] = 0;
      end
    end
  endtask

  task automatic chk(string req, int unsigned act, int unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    #1;
    for (int i = 0; i < NCH; i++) chk("R4 fire", 32'(fire[i]), 32'(m_fire(i)));
    chk("R10 read", rd_data, m_read(int'(rd_addr)));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr(int a, int unsigned d, bit [3:0] be);
    wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_be = be;
    tick();
    wr_en = 0;
  endtask

  task automatic rd_chk(string req, int a, int unsigned exp);
    rd_addr = AW'(a);
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wait_fire(int ch, int maxc, string req, int unsigned exp_cnt);
    bit seen = 0;
    rd_addr = AW'(1);
    for (int k = 0; k < maxc && !seen; k++) begin
      tick();
      if (fire[ch]) begin
        seen = 1;
        chk(req, rd_data, exp_cnt);
      end
    end
    chk(req, 32'(seen), 1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int unsigned exp_c;
    int fires;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    rd_chk("R1 ctrl", 0, 0);
    rd_chk("R1 cnt", 1, 0);
    rd_chk("R1 cmp0", 5, 32'hFFFF_FFFF);
    rd_chk("R1 cmp1", 9, 32'hFFFF_FFFF);
    rd_chk("R1 per1", 10, 0);
    rd_chk("R1 cfg0", 4, 0);
    chk("R1 fire", 32'(fire), 0);
    rd_chk("R10 unused", 3, 0);

    // R2 run and hold
    wr(0, 1, 4'b0001);
    idle(10);
    rd_chk("R2 running", 1, m_cnt);
    wr(0, 0, 4'b0001);
    rd_addr = 1; #1;
    exp_c = rd_data;
    idle(5);
    rd_chk("R2 hold", 1, exp_c);

    // R3 lane-masked counter write
    wr(1, 32'hAABB_1234, 4'b0011);
    rd_chk("R3 masked", 1, 32'h0000_1234);

    // R5 one-shot
    wr(5, 32'h0000_1240, 4'b1111);
    wr(0, 1, 4'b0001);
    wait_fire(0, 40, "R5 oneshot fire", 32'h0000_1240);
    tick();
    rd_chk("R5 cmp kept", 5, 32'h0000_1240);
    rd_chk("R5 per zero", 6, 0);
    wr(0, 0, 4'b0001);
    wr(5, 32'h0000_0005, 4'b0001);
    rd_chk("R5 lane write", 5, 32'h0000_1205);
    wr(1, 32'hFFFF_FFF0, 4'b1111);
    wr(0, 1, 4'b0001);
    wait_fire(0, 6000, "R5 after wrap", 32'h0000_1205);

    // R6 periodic loading
    wr(0, 0, 4'b0001);
    wr(1, 32'h20, 4'b1111);
    wr(8, 3, 4'b0001);
    rd_chk("R6 cfg set", 8, 3);
    wr(9, 32'h100, 4'b1111);
    rd_chk("R6 per", 10, 32'h100);
    rd_chk("R6 cmp", 9, 32'h100);
    rd_chk("R6 vset cleared", 8, 1);
    wr(9, 32'h80, 4'b1111);
    rd_chk("R6 per only", 10, 32'h80);
    rd_chk("R6 cmp kept", 9, 32'h100);

    // R7 periodic advance
    wr(0, 1, 4'b0001);
    wait_fire(1, 300, "R7 fire", 32'h100);
    tick();
    rd_chk("R7 advanced", 9, 32'h180);

    // R9 catch-up after counter write
    wr(0, 0, 4'b0001);
    wr(1, 32'h1000, 4'b1111);
    idle(40);
    rd_chk("R9 catch-up", 9, 32'h1080);
    wr(9, 32'h6000_0000, 4'b1111);
    wr(1, 32'hF000_0000, 4'b1111);
    idle(10);
    rd_chk("R9 wrapped", 9, 32'h2000_1080);

    // R8 leaving periodic mode
    wr(8, 0, 4'b0001);
    rd_chk("R8 per zeroed", 10, 0);
    rd_chk("R8 cfg", 8, 0);

    // R9 catch-up after periodic compare write, then run rise
    wr(1, 32'h50, 4'b1111);
    wr(8, 3, 4'b0001);
    wr(9, 32'h10, 4'b1111);
    idle(10);
    rd_chk("R9 cmp write catch-up", 9, 32'h60);
    wr(0, 1, 4'b0001);
    wait_fire(1, 40, "R7 fire after catch-up", 32'h60);
    tick();
    rd_chk("R7 second advance", 9, 32'h70);

    // R9 fire held off while the running counter overtakes catch-up
    wr(1, 32'h200, 4'b1111);
    fires = 0;
    for (int k = 0; k < 40; k++) begin
      tick();
      if (fire[1]) fires++;
    end
    chk("R9 fire held", 32'(fires), 0);
    rd_chk("R9 target", 9, 32'h210);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule